// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the 13-bit fetch address for an 8K-word program memory. Software can read and write the low eight bits directly. The upper five bits are never written on their own: they are taken from a separate five-bit high-address latch, and only at the moment the program counter is reloaded. How much of that latch is used depends on the kind of reload:

- A write to the low byte takes all five latch bits, so a computed jump can reach any word.
- A jump or a call brings an 11-bit target, which reaches anywhere inside a 2K-word page. The page itself comes from the top two latch bits.
- A return ignores the latch. It restores the full 13-bit address from an internal return stack.

The surrounding core gives one strobe per cycle for the operation it wants. The block works out the winner in a fixed priority order and updates the counter on the next rising clock edge:

- **Increment:** moves to the next word in sequence.
- **Low-byte write:** performs a computed jump.
- **Jump or call:** performs a paged branch. A call also saves the following address on the stack.
- **Return:** takes the saved address back off the stack.

The return stack holds eight entries in a ring. An occupancy state machine tracks how full it is, with three states:

- `STK_EMPTY`: no entries held.
- `STK_PARTIAL`: one to seven entries held.
- `STK_FULL`: eight entries held.

Its transitions are:

- **first push:** `STK_EMPTY` to `STK_PARTIAL`.
- **fill:** `STK_PARTIAL` to `STK_FULL`, on the push that brings the count to eight.
- **wrap push:** `STK_FULL` to `STK_FULL`. The oldest entry is overwritten and an overflow pulse is raised.
- **drain:** `STK_FULL` to `STK_PARTIAL`, on a pop.
- **last pop:** `STK_PARTIAL` to `STK_EMPTY`, when the final entry leaves.
- **empty pop:** `STK_EMPTY` to `STK_EMPTY`. The pointer still steps back.

Each operation is decoded into one of six arbiter codes: `OP_HOLD`, `OP_INC`, `OP_PCLWR`, `OP_JUMP`, `OP_CALL` and `OP_RET`.

Top module: `paged_pc_core`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, `pc`, `pcl_rdata` and `stk_ovf` are 0. The high-address latch and the stack occupancy are also cleared, so later low-byte writes use a latch value of 0.
- R2: With only `inc_en` active, `pc` becomes `pc+1` after the next rising edge, and 0x1FFF wraps to 0x0000. With no strobe active, `pc` holds its value.
- R3: A low-byte write loads `pc[7:0]` from `pcl_wdata` and `pc[12:8]` from latch bits 4:0.
- R4: A jump loads `pc[10:0]` from `tgt` and `pc[12:11]` from latch bits 4:3. It pushes nothing onto the stack.
- R5: A call loads `pc` the same way as a jump. It also pushes the address after the current `pc` (`pc+1`, wrapping at 0x1FFF) onto the return stack.
- R6: A return loads all 13 bits of `pc` from the most recently pushed entry that has not yet been popped, in last-in first-out order, whatever the latch holds.
- R7: The stack holds eight entries. A call made while eight entries are held overwrites the oldest entry and raises `stk_ovf` for exactly the one cycle that follows that edge; `stk_ovf` is 0 at all other times.
- R8: When several strobes are active in one cycle, the priority from highest to lowest is reset, return, call, jump, low-byte write, increment. Only the winner takes effect.
- R9: The latch changes only through `lat_we`. A latch write in the same cycle as a low-byte write or a branch takes effect only for later operations, and no program counter update ever alters the latch.
- R10: `pcl_rdata` always equals `pc[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step to the next sequential word |
| pcl_we | input | 1 | Write the low byte (computed jump) |
| pcl_wdata | input | 8 | Low-byte write data |
| lat_we | input | 1 | Write the high-address latch |
| lat_wdata | input | 5 | High-address latch write data |
| jmp_en | input | 1 | Paged jump to `tgt` |
| call_en | input | 1 | Paged call to `tgt`, saving the return address |
| tgt | input | 11 | In-page branch target |
| ret_en | input | 1 | Return to the last saved address |
| pc | output | 13 | Current program counter |
| pcl_rdata | output | 8 | Readback of the low byte |
| stk_ovf | output | 1 | One-cycle pulse when a call overwrites the oldest entry |

## Verification
A wrong latch value shows up on the upper `pc` bits at the first low-byte write or branch after it goes wrong. It can stay hidden for as long as only increments occur, so the bench writes the latch and reloads the counter within a few cycles of each other. A corrupted stack pointer or entry shows up only when returns are made, often many cycles later. The bench therefore nests calls, including nine deep to force a wrap, and unwinds every one of them. An occupancy state that is out of step with the real count shows up at the next call made with eight entries held: `stk_ovf` either fails to pulse or pulses at the wrong time.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    // Operation chosen for this cycle after priority resolution
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_PCLWR = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5
    } pc_op_e;

    // Occupancy of the return stack
    typedef enum logic [1:0] {
        STK_EMPTY   = 2'd0,
        STK_PARTIAL = 2'd1,
        STK_FULL    = 2'd2
    } stk_state_e;

endpackage

// File: rtl/ppc_op_arbiter.sv
module ppc_op_arbiter
    import ppc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc_en,
    input  logic   pcl_we,
    input  logic   jmp_en,
    input  logic   call_en,
    input  logic   ret_en,
    output pc_op_e op
);

    // Fixed priority: return > call > jump > low-byte write > increment
    always_comb begin
        if (ret_en)       op = OP_RET;
        else if (call_en) op = OP_CALL;
        else if (jmp_en)  op = OP_JUMP;
        else if (pcl_we)  op = OP_PCLWR;
        else if (inc_en)  op = OP_INC;
        else              op = OP_HOLD;
    end

    AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> (op == OP_RET)); // R8
    AST_CALL_BEATS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en && !ret_en) |-> (op == OP_CALL)); // R8
    AST_INC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && (ret_en || call_en || jmp_en || pcl_we)) |-> (op != OP_INC)); // R8

endmodule

// File: rtl/ppc_addr_reg.sv
module ppc_addr_reg
    import ppc_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int BR_W  = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pc_op_e                op,
    input  logic [LOW_W-1:0]      pcl_wdata,
    input  logic                  lat_we,
    input  logic [PC_W-LOW_W-1:0] lat_wdata,
    input  logic [BR_W-1:0]       tgt,
    input  logic [PC_W-1:0]       pop_addr,
    output logic [PC_W-1:0]       pc,
    output logic [PC_W-1:0]       pc_seq,
    output logic [LOW_W-1:0]      pcl_rdata
);

    localparam int HI_W = PC_W - LOW_W;   // latch bits used by a low-byte write
    localparam int PG_W = PC_W - BR_W;    // latch bits used as page on a branch

    logic [PC_W-1:0] pc_q;
    logic [HI_W-1:0] lat_q;

    // High-address latch: only its own write strobe changes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (lat_we) begin
            lat_q <= lat_wdata;
        end
    end

    // Program counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            unique case (op)
                OP_INC:           pc_q <= pc_q + PC_W'(1);
                OP_PCLWR:         pc_q <= {lat_q, pcl_wdata};
                OP_JUMP, OP_CALL: pc_q <= {lat_q[HI_W-1 -: PG_W], tgt};
                OP_RET:           pc_q <= pop_addr;
                default:          pc_q <= pc_q;
            endcase
        end
    end

    assign pc        = pc_q;
    assign pc_seq    = pc_q + PC_W'(1);
    assign pcl_rdata = pc_q[LOW_W-1:0];

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> (pc_q == $past(pc_q) + PC_W'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(pc_q)); // R2
    AST_PCL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PCLWR) |=> (pc_q[PC_W-1 -: HI_W] == $past(lat_q))); // R3
    AST_PAGE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP || op == OP_CALL) |=>
        (pc_q[PC_W-1 -: PG_W] == $past(lat_q[HI_W-1 -: PG_W]))); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_we |=> $stable(lat_q)); // R9

endmodule

// File: rtl/ppc_ret_stack.sv
module ppc_ret_stack
    import ppc_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    stk_state_e       state, state_nx;
    logic [PTR_W-1:0] sp;        // next free slot
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    mem [DEPTH];

    // Next-state logic for occupancy
    always_comb begin
        state_nx = state;
        unique case (state)
            STK_EMPTY: begin
                if (push) state_nx = (DEPTH == 1) ? STK_FULL : STK_PARTIAL;  // first push
            end
            STK_PARTIAL: begin
                if (push && cnt == CNT_LAST)  state_nx = STK_FULL;           // fill
                else if (pop && cnt == CNT_W'(1)) state_nx = STK_EMPTY;      // last pop
            end
            STK_FULL: begin
                if (pop) state_nx = (DEPTH == 1) ? STK_EMPTY : STK_PARTIAL;  // drain
            end
            default: state_nx = STK_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STK_EMPTY;
        else        state <= state_nx;
    end

    // Pointer, count and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= push_data;
            sp      <= sp + PTR_W'(1);
            if (state != STK_FULL) cnt <= cnt + CNT_W'(1);
        end else if (pop) begin
            sp <= sp - PTR_W'(1);
            if (state != STK_EMPTY) cnt <= cnt - CNT_W'(1);
        end
    end

    // Outputs: overflow pulse on a wrap push
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= push && (state == STK_FULL);
    end

    assign top_data = mem[sp - PTR_W'(1)];

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state == STK_FULL) |=> ovf); // R7
    AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && state == STK_FULL) |=> !ovf); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX); // R7
    AST_FULL_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STK_FULL) |-> (cnt == CNT_MAX)); // R7
    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R8

endmodule

// File: rtl/paged_pc_core.sv
module paged_pc_core
    import ppc_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LOW_W     = 8,
    parameter int BR_W      = 11,
    parameter int STK_DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_en,
    input  logic                  pcl_we,
    input  logic [LOW_W-1:0]      pcl_wdata,
    input  logic                  lat_we,
    input  logic [PC_W-LOW_W-1:0] lat_wdata,
    input  logic                  jmp_en,
    input  logic                  call_en,
    input  logic [BR_W-1:0]       tgt,
    input  logic                  ret_en,
    output logic [PC_W-1:0]       pc,
    output logic [LOW_W-1:0]      pcl_rdata,
    output logic                  stk_ovf
);

    pc_op_e          op;
    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] stk_top;

    ppc_op_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .pcl_we  (pcl_we),
        .jmp_en  (jmp_en),
        .call_en (call_en),
        .ret_en  (ret_en),
        .op      (op)
    );

    ppc_addr_reg #(
        .PC_W  (PC_W),
        .LOW_W (LOW_W),
        .BR_W  (BR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .pcl_wdata (pcl_wdata),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata),
        .tgt       (tgt),
        .pop_addr  (stk_top),
        .pc        (pc),
        .pc_seq    (pc_seq),
        .pcl_rdata (pcl_rdata)
    );

    ppc_ret_stack #(
        .AW    (PC_W),
        .DEPTH (STK_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (op == OP_CALL),
        .pop       (op == OP_RET),
        .push_data (pc_seq),
        .top_data  (stk_top),
        .ovf       (stk_ovf)
    );

    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> (pc == $past(stk_top))); // R6
    AST_CALL_SAVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> (u_stk.mem[u_stk.sp - 1'b1] == $past(pc) + PC_W'(1))); // R5

endmodule

// File: tb/tb_paged_pc_core.sv
`timescale 1ns/1ps
module tb_paged_pc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_en = 0, pcl_we = 0, lat_we = 0, jmp_en = 0, call_en = 0, ret_en = 0;
    logic [7:0]  pcl_wdata = '0;
    logic [4:0]  lat_wdata = '0;
    logic [10:0] tgt = '0;
    logic [12:0] pc;
    logic [7:0]  pcl_rdata;
    logic        stk_ovf;

    always #2 clk = ~clk;   // 250 MHz

    paged_pc_core dut (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
        .lat_we(lat_we), .lat_wdata(lat_wdata), .jmp_en(jmp_en), .call_en(call_en),
        .tgt(tgt), .ret_en(ret_en), .pc(pc), .pcl_rdata(pcl_rdata), .stk_ovf(stk_ovf)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // Scoreboard queues
    logic [12:0] q_pc[$];
    bit          q_ovf[$];
    string       q_tag[$];

    // Reference model state
    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0, m_cnt = 0;

    task automatic model_clear();
        m_pc = '0; m_lat = '0; m_sp = 0; m_cnt = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
    endtask

    // Driver: one cycle of stimulus, expected result queued
    task automatic step(input bit i_inc, input bit i_pclw, input logic [7:0] i_d,
                        input bit i_latw, input logic [4:0] i_ld, input bit i_jmp,
                        input bit i_call, input logic [10:0] i_t, input bit i_ret,
                        input string tag);
        bit ovf_e;
        @(negedge clk);
        inc_en = i_inc; pcl_we = i_pclw; pcl_wdata = i_d; lat_we = i_latw; lat_wdata = i_ld;
        jmp_en = i_jmp; call_en = i_call; tgt = i_t; ret_en = i_ret;
        ovf_e = 1'b0;
        if (i_ret) begin
            m_sp = (m_sp + 7) % 8;
            m_pc = m_stk[m_sp];
            if (m_cnt > 0) m_cnt--;
        end else if (i_call) begin
            ovf_e = (m_cnt == 8);
            m_stk[m_sp] = m_pc + 13'd1;
            m_sp = (m_sp + 1) % 8;
            if (m_cnt < 8) m_cnt++;
            m_pc = {m_lat[4:3], i_t};
        end else if (i_jmp) begin
            m_pc = {m_lat[4:3], i_t};
        end else if (i_pclw) begin
            m_pc = {m_lat, i_d};
        end else if (i_inc) begin
            m_pc = m_pc + 13'd1;
        end
        if (i_latw) m_lat = i_ld;
        q_pc.push_back(m_pc);
        q_ovf.push_back(ovf_e);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);      step(0,0,8'h0,0,5'h0,0,0,11'h0,0,tag); endtask
    task automatic inc(input string tag);       step(1,0,8'h0,0,5'h0,0,0,11'h0,0,tag); endtask
    task automatic pclw(input logic [7:0] d, input string tag); step(0,1,d,0,5'h0,0,0,11'h0,0,tag); endtask
    task automatic latw(input logic [4:0] v, input string tag); step(0,0,8'h0,1,v,0,0,11'h0,0,tag); endtask
    task automatic jmp(input logic [10:0] t, input string tag); step(0,0,8'h0,0,5'h0,1,0,t,0,tag); endtask
    task automatic call(input logic [10:0] t, input string tag); step(0,0,8'h0,0,5'h0,0,1,t,0,tag); endtask
    task automatic ret(input string tag);       step(0,0,8'h0,0,5'h0,0,0,11'h0,1,tag); endtask

    task automatic check(input bit ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_pc.size() > 0) begin
                logic [12:0] e_pc;
                bit e_ovf;
                string t;
                e_pc = q_pc.pop_front(); e_ovf = q_ovf.pop_front(); t = q_tag.pop_front();
                check(pc === e_pc, {t, " pc"}, pc, e_pc);
                check(pcl_rdata === e_pc[7:0], {t, " R10 readback"}, {5'h0, pcl_rdata}, {5'h0, e_pc[7:0]});
                check(stk_ovf === e_ovf, {t, " stk_ovf"}, {12'h0, stk_ovf}, {12'h0, e_ovf});
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        inc_en = 0; pcl_we = 0; lat_we = 0; jmp_en = 0; call_en = 0; ret_en = 0;
        model_clear();
        #0.5;
        check(pc === 13'h0, {tag, " pc in reset"}, pc, 13'h0);
        check(pcl_rdata === 8'h0, {tag, " readback in reset"}, {5'h0, pcl_rdata}, 13'h0);
        check(stk_ovf === 1'b0, {tag, " ovf in reset"}, {12'h0, stk_ovf}, 13'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        model_clear();
        do_reset("R1 power-on");

        // R2: increments, with a latch write riding along
        step(1,0,8'h0,1,5'h15,0,0,11'h0,0,"R2 inc with latch write");
        inc("R2 inc");
        idle("R2 hold");
        inc("R2 inc");
        // R3: computed jump uses all five latch bits
        pclw(8'h34, "R3 low-byte write");
        // R9: latch written same cycle as low-byte write: old latch used
        step(0,1,8'h77,1,5'h0A,0,0,11'h0,0,"R9 old latch on pcl write");
        pclw(8'h01, "R9 new latch visible");
        // R4: paged jump, page from latch bits 4:3 (0x0A -> 01)
        jmp(11'h7FF, "R4 jump");
        // R5: call pushes next address
        call(11'h123, "R5 call");
        inc("R5 inc in callee");
        call(11'h400, "R5 nested call");
        latw(5'h1F, "R9 latch change only");
        call(11'h055, "R5 call new page");
        // R6: returns ignore latch, LIFO
        ret("R6 return 3");
        ret("R6 return 2");
        ret("R6 return 1");
        // R2 wrap
        pclw(8'hFF, "R3 to top of space");
        inc("R2 wrap to zero");
        inc("R2 after wrap");
        // R8 priority cases
        call(11'h010, "R8 setup call");
        step(1,1,8'h99,0,5'h0,1,1,11'h222,1,"R8 return wins all");
        step(0,0,8'h0,0,5'h0,1,1,11'h333,0,"R8 call beats jump");
        ret("R8 return of that call");
        step(1,1,8'h42,0,5'h0,1,0,11'h044,0,"R8 jump beats write and inc");
        step(1,1,8'h42,0,5'h0,0,0,11'h0,0,"R8 write beats inc");
        // R7 overflow: nine nested calls then eight returns
        latw(5'h08, "R7 setup latch");
        for (int k = 0; k < 9; k++) call(11'h100 + 11'(k * 16), "R7 deep call");
        idle("R7 ovf pulse ends");
        for (int k = 0; k < 8; k++) ret("R7 unwind after wrap");
        // R1 mid-run reset clears latch and stack
        call(11'h0AA, "R1 pre-reset call");
        do_reset("R1 mid-run");
        pclw(8'h5A, "R1 latch cleared");
        idle("R1 settle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule